// File: doc/BRIEF.md
# Programmable DRAM Refresh Address Sequencer

The block turns an external, slowly toggling refresh request into DRAM refresh read cycles on a simple bus-master port. Each high-to-low transition of the request input, while refresh is enabled, yields exactly one read cycle. The read carries a 24-bit address and a 3-bit function code. Software programs a start address, a row stride in bytes and a row count. A working pointer and a working row counter walk the rows and wrap back to the start after a full sweep.

A controller state machine with three states drives the bus port. `ST_IDLE` waits for a qualified trigger. Transition *launch* (IDLE to BUS) is taken when a trigger is present. `ST_BUS` holds `bus_req`/`bus_rd` with a stable address. Transition *complete* (BUS to STEP) is taken on `bus_done`. `ST_STEP` advances or reloads the working pointer and count. Transition *retire* (STEP to IDLE) is always taken. A request edge that arrives while the controller is busy is kept as a single pending trigger.

Register map on `reg_addr`:
- 0: control, with bit 0 as the enable.
- 1: start high word, with the function code in bits 14:12 and address bits 23:16 in bits 7:0.
- 2: start low word, holding address bits 15:0.
- 3: row stride.
- 4: row count.
- 5: working high word, in the same layout as offset 1, with the function code taken from offset 1.
- 6: working low word.
- 7: working row count.

Top module: `dram_refresh_seq`

## Requirements
- R1: A refresh cycle is launched only by a high-to-low transition of `rfsh_req_n`. A steady level or a rising transition launches nothing.
- R2: While control bit 0 (offset 0) is 0, request edges launch no cycle, are not kept pending, and leave the working registers unchanged.
- R3: Offset 1 stores the function code in bits 14:12 and address bits 23:16 in bits 7:0. Bits 15 and 11:8 always read as 0.
- R4: During a cycle, `bus_req` and `bus_rd` are 1, `bus_addr` is the working pointer, and `bus_fc` is the stored function code. These stay stable until `bus_done`, and `bus_req` is 0 on the cycle after `bus_done`.
- R5: When the stored function code is 3'b111, `fc_err` is 1 and no cycle is launched. Edges seen in that state are dropped.
- R6: After each cycle, the 24-bit working pointer (offsets 5 and 6) grows by the stride, with the carry passing into bits 23:16. The working count (offset 7) drops by 1.
- R7: When a cycle leaves the working count at zero, the pointer reloads from the start address and the count reloads from offset 4.
- R8: One edge that arrives during a cycle is held and served right after it. Further edges in that time are dropped.
- R9: Every register is readable at any time through `reg_rdata` (combinational on `reg_addr`), and reads do not alter the sequence. The working registers are also writable.
- R10: After reset, `bus_req` and `fc_err` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| rfsh_req_n | input | 1 | External refresh request, falling-edge active |
| bus_req | output | 1 | Refresh bus cycle request |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | 24 | Refresh address |
| bus_fc | output | 3 | Function code |
| bus_done | input | 1 | Bus cycle complete |
| fc_err | output | 1 | Function code 3'b111 loaded |

## Verification
When `rfsh_req_n` falls just before clock edge k, the two-stage synchronizer and the edge register raise the trigger after edge k+1. `bus_req` is then high after edge k+2. `bus_req` drops one edge after `bus_done` is sampled. The updated working pointer and count can be read back one edge later. The bench drives every input at the falling clock edge and samples at the following falling edges. It checks that `bus_req` is still low before its due edge and high exactly at it. A held edge relaunches two edges after the current cycle ends, and the bench allows a short bounded wait for it.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    localparam int WORD_W = 16;
    localparam int FC_W   = 3;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_CTRL     = 3'd0;
    localparam logic [OFS_W-1:0] OFS_START_HI = 3'd1;
    localparam logic [OFS_W-1:0] OFS_START_LO = 3'd2;
    localparam logic [OFS_W-1:0] OFS_STRIDE   = 3'd3;
    localparam logic [OFS_W-1:0] OFS_ROWS     = 3'd4;
    localparam logic [OFS_W-1:0] OFS_WORK_HI  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_WORK_LO  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_WORK_CNT = 3'd7;

    localparam logic [FC_W-1:0] FC_ILLEGAL = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_STEP = 2'd2
    } seq_state_t;
endpackage

// File: rtl/refresh_trig.sv
module refresh_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic armed,
    input  logic busy,
    output logic start
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pend_q;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= req_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_n};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall = last_q & ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!armed) begin
            pend_q <= 1'b0;
        end else if (busy) begin
            if (fall) pend_q <= 1'b1;
        end else begin
            pend_q <= 1'b0;
        end
    end

    assign start = armed & (fall | pend_q);
endmodule

// File: rtl/refresh_regs.sv
module refresh_regs
    import refresh_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic [ADDR_W-1:0]    work_ptr,
    input  logic [CNT_W-1:0]     work_cnt,
    output logic                 enable,
    output logic [FC_W-1:0]      fc,
    output logic [ADDR_W-1:0]    start_addr,
    output logic [WORD_W-1:0]    stride,
    output logic [CNT_W-1:0]     rows
);
    localparam int HI_W  = ADDR_W - WORD_W;
    localparam int PAD_W = 8 - HI_W;

    logic [HI_W-1:0]   hi_q;
    logic [WORD_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            fc     <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            stride <= '0;
            rows   <= '0;
        end else if (wr) begin
            unique case (ofs)
                OFS_CTRL:     enable <= wdata[0];
                OFS_START_HI: begin
                    fc   <= wdata[14:12];
                    hi_q <= wdata[HI_W-1:0];
                end
                OFS_START_LO: lo_q   <= wdata;
                OFS_STRIDE:   stride <= wdata;
                OFS_ROWS:     rows   <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign start_addr = {hi_q, lo_q};

    function automatic logic [WORD_W-1:0] pack_hi(input logic [FC_W-1:0] f,
                                                  input logic [HI_W-1:0] a);
        logic [7:0] byte_v;
        byte_v = {{PAD_W{1'b0}}, a};
        return {1'b0, f, 4'b0000, byte_v};
    endfunction

    always_comb begin
        rdata = '0;
        unique case (ofs)
            OFS_CTRL:     rdata = {{(WORD_W-1){1'b0}}, enable};
            OFS_START_HI: rdata = pack_hi(fc, hi_q);
            OFS_START_LO: rdata = lo_q;
            OFS_STRIDE:   rdata = stride;
            OFS_ROWS:     rdata = WORD_W'(rows);
            OFS_WORK_HI:  rdata = pack_hi(fc, work_ptr[ADDR_W-1:WORD_W]);
            OFS_WORK_LO:  rdata = work_ptr[WORD_W-1:0];
            OFS_WORK_CNT: rdata = WORD_W'(work_cnt);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/refresh_ptr.sv
module refresh_ptr
    import refresh_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] wdata,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] stride,
    input  logic [CNT_W-1:0]  rows,
    output logic [ADDR_W-1:0] work_ptr,
    output logic [CNT_W-1:0]  work_cnt
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic sweep_end;
    assign sweep_end = (work_cnt <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_ptr <= '0;
            work_cnt <= '0;
        end else if (wr && ofs == OFS_WORK_HI) begin
            work_ptr[ADDR_W-1:WORD_W] <= wdata[HI_W-1:0];
        end else if (wr && ofs == OFS_WORK_LO) begin
            work_ptr[WORD_W-1:0] <= wdata;
        end else if (wr && ofs == OFS_WORK_CNT) begin
            work_cnt <= wdata[CNT_W-1:0];
        end else if (advance) begin
            if (sweep_end) begin
                work_ptr <= start_addr;
                work_cnt <= rows;
            end else begin
                work_ptr <= work_ptr + ADDR_W'(stride);
                work_cnt <= work_cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import refresh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic bus_req,
    output logic bus_rd,
    output logic advance,
    output logic busy
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_BUS;
            ST_BUS:  if (done)  state_d = ST_STEP;
            ST_STEP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req = 1'b0;
        bus_rd  = 1'b0;
        advance = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_BUS: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
            end
            ST_STEP: advance = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import refresh_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rfsh_req_n,
    output logic              bus_req,
    output logic              bus_rd,
    output logic [23:0]       bus_addr,
    output logic [2:0]        bus_fc,
    input  logic              bus_done,
    output logic              fc_err
);
    logic              enable;
    logic [FC_W-1:0]   fc;
    logic [ADDR_W-1:0] start_addr;
    logic [WORD_W-1:0] stride;
    logic [CNT_W-1:0]  rows;
    logic [ADDR_W-1:0] work_ptr;
    logic [CNT_W-1:0]  work_cnt;
    logic              start_w;
    logic              advance;
    logic              busy;
    logic              armed;

    refresh_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .ofs(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .work_ptr(work_ptr), .work_cnt(work_cnt),
        .enable(enable), .fc(fc), .start_addr(start_addr),
        .stride(stride), .rows(rows)
    );

    refresh_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .ofs(reg_addr),
        .wdata(reg_wdata), .advance(advance), .start_addr(start_addr),
        .stride(stride), .rows(rows),
        .work_ptr(work_ptr), .work_cnt(work_cnt)
    );

    assign fc_err = (fc == FC_ILLEGAL);
    assign armed  = enable & ~fc_err;

    refresh_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .req_n(rfsh_req_n),
        .armed(armed), .busy(busy), .start(start_w)
    );

    refresh_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_w), .done(bus_done),
        .bus_req(bus_req), .bus_rd(bus_rd), .advance(advance), .busy(busy)
    );

    assign bus_addr = 24'(work_ptr);
    assign bus_fc   = fc;
endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_done,
    input logic [23:0] bus_addr,
    input logic [2:0]  bus_fc,
    input logic        fc_err,
    input logic        trig_start
);
    p_legal_fc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (!fc_err && bus_fc != 3'b111));

    p_hold_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_fc)));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done) |=> !bus_req);

    p_launch_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(trig_start));
endmodule

bind dram_refresh_seq refresh_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_done(bus_done),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .fc_err(fc_err),
    .trig_start(start_w)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
    localparam realtime CYC = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rfsh_req_n = 1'b1;
    logic        bus_req, bus_rd, fc_err;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CYC/2) clk = ~clk;

    dram_refresh_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rfsh_req_n(rfsh_req_n),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_fc(bus_fc), .bus_done(bus_done), .fc_err(fc_err)
    );

    // {address during cycle, working pointer after, working count after}
    localparam logic [63:0] VEC [6] = '{
        {24'h12FFF0, 24'h130000, 16'd2},
        {24'h130000, 24'h130010, 16'd1},
        {24'h130010, 24'h12FFF0, 16'd3},
        {24'h12FFF0, 24'h130000, 16'd2},
        {24'h130000, 24'h130010, 16'd1},
        {24'h130010, 24'h12FFF0, 16'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle_high();
        rfsh_req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One full refresh cycle with exact timing checks
    task automatic one_cycle(input logic [23:0] exp_addr, input logic [23:0] exp_next,
                             input logic [15:0] exp_cnt);
        logic [15:0] d;
        @(negedge clk);
        rfsh_req_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 no early req", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        chk("R1 req due", {31'd0, bus_req}, 32'd1);
        chk("R4 rd strobe", {31'd0, bus_rd}, 32'd1);
        chk("R4 addr", {8'd0, bus_addr}, {8'd0, exp_addr});
        chk("R4 fc", {29'd0, bus_fc}, 32'd2);
        @(negedge clk);
        chk("R4 held", {31'd0, bus_req}, 32'd1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        chk("R4 release", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        rd_reg(3'd6, d);
        chk("R6/R7 ptr lo", {16'd0, d}, {16'd0, exp_next[15:0]});
        rd_reg(3'd5, d);
        chk("R6/R7 ptr hi", {16'd0, d}, {16'd0, 8'h20, exp_next[23:16]});
        rd_reg(3'd7, d);
        chk("R6/R7 count", {16'd0, d}, {16'd0, exp_cnt});
        settle_high();
    endtask

    task automatic setup_sweep();
        wr_reg(3'd1, 16'h2012);
        wr_reg(3'd2, 16'hFFF0);
        wr_reg(3'd3, 16'h0010);
        wr_reg(3'd4, 16'd3);
        wr_reg(3'd5, 16'h0012);
        wr_reg(3'd6, 16'hFFF0);
        wr_reg(3'd7, 16'd3);
    endtask

    task automatic expect_quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_req) seen = 1;
        end
        chk(req, seen, 0);
    endtask

    initial begin : watchdog
        #(CYC * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        logic [15:0] snap [8];
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R10 fc_err", {31'd0, fc_err}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), d);
            chk("R10 reg zero", {16'd0, d}, 32'd0);
        end

        // R2 disabled: edges ignored, working pointer untouched
        setup_sweep();
        @(negedge clk); rfsh_req_n = 1'b0;
        expect_quiet("R2 disabled no cycle", 10);
        rd_reg(3'd6, d);
        chk("R2 ptr unchanged", {16'd0, d}, 32'h0000FFF0);
        // R1 enable while low, then a rising edge: nothing
        wr_reg(3'd0, 16'h0001);
        expect_quiet("R1 level low", 6);
        rfsh_req_n = 1'b1;
        expect_quiet("R1 rising edge", 6);

        // Vector table: R4, R6, R7 across a sweep with carry and wrap
        for (int v = 0; v < 6; v++)
            one_cycle(VEC[v][63:40], VEC[v][39:16], VEC[v][15:0]);

        // R9: reads have no side effects
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 8; a++) begin
                rd_reg(3'(a), d);
                if (r == 0) snap[a] = d;
                else chk("R9 read stable", {16'd0, d}, {16'd0, snap[a]});
            end
        one_cycle(24'h12FFF0, 24'h130000, 16'd2);

        // R8: one held edge served, extra edges dropped
        @(negedge clk); rfsh_req_n = 1'b0;
        seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            @(negedge clk);
            if (bus_req) seen = 1;
        end
        chk("R8 first cycle", seen, 1);
        settle_high(); rfsh_req_n = 1'b0; repeat (4) @(negedge clk);
        settle_high(); rfsh_req_n = 1'b0; repeat (4) @(negedge clk);
        chk("R8 still in first", {31'd0, bus_req}, 32'd1);
        bus_done = 1'b1; @(negedge clk); bus_done = 1'b0;
        seen = 0;
        for (int i = 0; i < 5 && !seen; i++) begin
            @(negedge clk);
            if (bus_req) seen = 1;
        end
        chk("R8 pending served", seen, 1);
        chk("R8 pending addr", {8'd0, bus_addr}, 32'h00130010);
        bus_done = 1'b1; @(negedge clk); bus_done = 1'b0;
        expect_quiet("R8 extra edge dropped", 12);
        settle_high();

        // R3 / R5: illegal function code
        wr_reg(3'd1, 16'hFFFF);
        @(negedge clk);
        chk("R5 fc_err set", {31'd0, fc_err}, 32'd1);
        rd_reg(3'd1, d);
        chk("R3 hi layout", {16'd0, d}, 32'h000070FF);
        rfsh_req_n = 1'b0;
        expect_quiet("R5 no cycle", 10);
        settle_high();
        wr_reg(3'd1, 16'h8F05);
        @(negedge clk);
        rd_reg(3'd1, d);
        chk("R3 reserved zero", {16'd0, d}, 32'h00000005);
        chk("R5 fc_err clear", {31'd0, fc_err}, 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule